// File: doc/BRIEF.md
# Manual Burst Access Buffer

This block gives software direct, hand-driven access to an external memory that is normally exercised by an automatic test engine. It keeps a staging buffer of `DEPTH` wide bus words. Software fills and inspects that buffer through a narrow 32-bit register port, one slice at a time. A single command then moves the buffer to memory as one burst write, or fetches one burst from memory into the buffer.

The block acts as a burst-capable memory master. A multiplexer hands the memory bus to this master only while the manual-access enable is set. While the enable is clear, the test engine's request signals pass straight through to the memory bus. The memory address and the burst length are configuration registers. They are captured when a command starts and stay fixed for the whole transfer.

Register indices are 32-bit word indices on `reg_addr`. Index 0 is the control register: bit 0 is the enable, bit 1 starts a write, bit 2 starts a read, and bit 3 reads back busy. Index 1 is the memory address and index 2 is the burst length. The buffer window starts at index 64.

Top module: `burst_stage_master`

## Requirements
- R1: After reset, the enable, busy, memory address, burst length and every buffer slice read back as zero, and the memory bus carries the test engine's signals.
- R2: Buffer word `w`, slice `s` sits at register index 64 + w*SLICES + s, where slice 0 holds bits 31:0. A register write while idle stores the slice. A read returns it on `reg_rdata`, with `reg_rvalid` high, in the cycle after `reg_rd`.
- R3: With the enable clear, `mem_*` equal `eng_*`. With the enable set and no transfer running, `mem_read` and `mem_write` are low whatever the engine drives.
- R4: A write command (control value with bit 1 set, bit 2 clear) raises `mem_write` in the next cycle. `mem_address` and `mem_burst` come from the configuration. Buffer words 0, 1, … are presented in order, and the block moves to the next word only in a cycle where `mem_ready` is high. Exactly `burst` words are sent.
- R5: A read command (bit 2 set, bit 1 clear) holds `mem_read` high until one cycle with `mem_ready` high, then drops it. The next `burst` cycles with `mem_rvalid` high store `mem_rdata` into buffer words 0 to burst-1. Other words keep their values.
- R6: Busy (control bit 3) is high from the cycle after a command until the last word has been accepted (write) or received (read). It is low again when software next reads the control register.
- R7: A command is ignored in any of these cases: the enable was clear before the write, a transfer is running, the burst length is 0 or greater than DEPTH, or bits 1 and 2 are both set.
- R8: While busy, register writes to the enable, address, burst length and buffer window have no effect. This includes a buffer write that lands in the same cycle as a returning read word.
- R9: A `mem_rvalid` pulse outside an outstanding manual read leaves the buffer unchanged.
- R10: The address register (index 1) and the burst register (index 2) read back the last values written while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| eng_read | input | 1 | Test engine read request |
| eng_write | input | 1 | Test engine write request |
| eng_address | input | ADDR_W | Test engine address |
| eng_wdata | input | DATA_W | Test engine write data |
| eng_burst | input | BURST_W | Test engine burst length |
| mem_ready | input | 1 | Memory accepts the current request or word |
| mem_rdata | input | DATA_W | Memory read data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_read | output | 1 | Read request to memory |
| mem_write | output | 1 | Write request to memory, high for every word |
| mem_address | output | ADDR_W | Memory address of the burst |
| mem_wdata | output | DATA_W | Memory write data |
| mem_burst | output | BURST_W | Burst length in words |

## Verification
Two functions compete for the buffer and can fall in the same cycle: a software write into the buffer window, and a read word returning from memory into the same storage.

The bench provokes this by driving a buffer-window register write on exactly the falling edge where it also raises `mem_rvalid` for the first word of a read burst. It then reads the whole buffer back and expects the memory word, not the register value.

Configuration writes and a second command are likewise issued during a stalled write burst. The bench then confirms, from the bus signals and later register reads, that the running transfer kept its address, length and data.

// File: rtl/bsm_pkg.sv
// Package: shared constants and types for the manual burst access buffer.
// Assumes 32-bit register slices and word-indexed register addresses.
package bsm_pkg;
    localparam int SLICE_W    = 32;
    localparam int REG_CTRL   = 0;
    localparam int REG_ADDR   = 1;
    localparam int REG_BURST  = 2;
    localparam int REG_WIN    = 64;
    localparam int CTRL_EN    = 0;
    localparam int CTRL_GO_WR = 1;
    localparam int CTRL_GO_RD = 2;
    localparam int CTRL_BUSY  = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WRITE   = 2'd1,
        ST_RD_REQ  = 2'd2,
        ST_RD_DATA = 2'd3
    } eng_state_t;
endpackage

// File: rtl/bsm_regs.sv
// Module: bsm_regs
// Register file and decoder. It holds the enable, address and burst-length
// configuration, decodes the buffer window, and turns control writes into
// one-cycle start pulses. It assumes that SLICES and DEPTH are powers of two,
// that SLICES >= 2, and that ADDR_W <= 32.
module bsm_regs import bsm_pkg::*; #(
    parameter int ADDR_W  = 24,
    parameter int BURST_W = 3,
    parameter int REG_AW  = 8,
    parameter int DEPTH   = 4,
    parameter int SLICES  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [REG_AW-1:0]          reg_addr,
    input  logic [31:0]                reg_wdata,
    output logic [31:0]                reg_rdata,
    output logic                       reg_rvalid,
    input  logic                       busy,
    input  logic [SLICE_W-1:0]         buf_slice_rd,
    output logic                       buf_we,
    output logic [$clog2(DEPTH)-1:0]   buf_word,
    output logic [$clog2(SLICES)-1:0]  buf_slice,
    output logic                       cfg_en,
    output logic [ADDR_W-1:0]          cfg_addr,
    output logic [BURST_W-1:0]         cfg_burst,
    output logic                       go_wr,
    output logic                       go_rd
);
    localparam int WORD_W   = $clog2(DEPTH);
    localparam int SL_W     = $clog2(SLICES);
    localparam int WIN_SIZE = DEPTH * SLICES;
    localparam logic [BURST_W:0] DEPTH_B = (BURST_W+1)'(DEPTH);

    logic [REG_AW-1:0] win_off;
    logic              win_hit;
    logic              ctrl_hit;
    logic              burst_ok;
    logic              go_ok;
    logic [31:0]       rd_mux;

    // Decode the buffer window and the word and slice it selects.
    always_comb begin
        win_off   = reg_addr - REG_AW'(REG_WIN);
        win_hit   = (reg_addr >= REG_AW'(REG_WIN)) && (win_off < REG_AW'(WIN_SIZE));
        buf_word  = win_off[SL_W +: WORD_W];
        buf_slice = win_off[SL_W-1:0];
        buf_we    = reg_wr && win_hit && !busy;
    end

    // Qualify a control write as a start command.
    always_comb begin
        ctrl_hit = reg_wr && (reg_addr == REG_AW'(REG_CTRL));
        burst_ok = (cfg_burst != '0) && ({1'b0, cfg_burst} <= DEPTH_B);
        go_ok    = ctrl_hit && cfg_en && !busy && burst_ok
                   && (reg_wdata[CTRL_GO_WR] ^ reg_wdata[CTRL_GO_RD]);
        go_wr    = go_ok && reg_wdata[CTRL_GO_WR];
        go_rd    = go_ok && reg_wdata[CTRL_GO_RD];
    end

    // Configuration registers, frozen while a transfer is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en    <= 1'b0;
            cfg_addr  <= '0;
            cfg_burst <= '0;
        end else if (reg_wr && !busy) begin
            if (reg_addr == REG_AW'(REG_CTRL))  cfg_en    <= reg_wdata[CTRL_EN];
            if (reg_addr == REG_AW'(REG_ADDR))  cfg_addr  <= reg_wdata[ADDR_W-1:0];
            if (reg_addr == REG_AW'(REG_BURST)) cfg_burst <= reg_wdata[BURST_W-1:0];
        end
    end

    // Select the read-back value for the addressed register.
    always_comb begin
        rd_mux = '0;
        if (reg_addr == REG_AW'(REG_CTRL)) begin
            rd_mux[CTRL_EN]   = cfg_en;
            rd_mux[CTRL_BUSY] = busy;
        end else if (reg_addr == REG_AW'(REG_ADDR)) begin
            rd_mux = 32'(cfg_addr);
        end else if (reg_addr == REG_AW'(REG_BURST)) begin
            rd_mux = 32'(cfg_burst);
        end else if (win_hit) begin
            rd_mux = buf_slice_rd;
        end
    end

    // Register the read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) reg_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/bsm_buffer.sv
// Module: bsm_buffer
// Staging buffer of DEPTH wide words, stored as 32-bit slices. The memory
// side writes whole words, the register side writes single slices, and a
// memory-side write in the same cycle takes priority over any register write.
module bsm_buffer import bsm_pkg::*; #(
    parameter int DATA_W = 128,
    parameter int DEPTH  = 4,
    parameter int SLICES = DATA_W / SLICE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sw_we,
    input  logic [$clog2(DEPTH)-1:0]   sw_word,
    input  logic [$clog2(SLICES)-1:0]  sw_slice,
    input  logic [SLICE_W-1:0]         sw_data,
    output logic [SLICE_W-1:0]         sw_rd_data,
    input  logic                       bus_we,
    input  logic [$clog2(DEPTH)-1:0]   bus_word,
    input  logic [DATA_W-1:0]          bus_data,
    output logic [DATA_W-1:0]          bus_rd_data
);
    localparam int WORD_W = $clog2(DEPTH);
    localparam int SL_W   = $clog2(SLICES);

    logic [SLICE_W-1:0] store [DEPTH][SLICES];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        for (genvar s = 0; s < SLICES; s++) begin : g_slice
            // One slice: a memory word wins, otherwise a register write lands.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    store[w][s] <= '0;
                end else if (bus_we) begin
                    if (bus_word == WORD_W'(w)) store[w][s] <= bus_data[s*SLICE_W +: SLICE_W];
                end else if (sw_we && sw_word == WORD_W'(w) && sw_slice == SL_W'(s)) begin
                    store[w][s] <= sw_data;
                end
            end
        end
    end

    // Register-side read of one slice.
    assign sw_rd_data = store[sw_word][sw_slice];

    for (genvar s = 0; s < SLICES; s++) begin : g_rd
        // Memory-side read of a full word for write bursts.
        assign bus_rd_data[s*SLICE_W +: SLICE_W] = store[bus_word][s];
    end
endmodule

// File: rtl/bsm_engine.sv
// Module: bsm_engine
// Sequencer for one burst transfer. It captures the address and length on
// start, steps write words on ready, and issues a single read request before
// it counts returning words. It assumes DEPTH < 2**BURST_W.
module bsm_engine import bsm_pkg::*; #(
    parameter int ADDR_W  = 24,
    parameter int BURST_W = 3,
    parameter int DEPTH   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go_wr,
    input  logic                      go_rd,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic [BURST_W-1:0]        cfg_burst,
    input  logic                      mem_ready,
    input  logic                      mem_rvalid,
    output logic                      busy,
    output logic                      m_read,
    output logic                      m_write,
    output logic [ADDR_W-1:0]         m_addr,
    output logic [BURST_W-1:0]        m_burst,
    output logic [$clog2(DEPTH)-1:0]  word_idx,
    output logic                      bus_we
);
    localparam int WORD_W = $clog2(DEPTH);

    eng_state_t         state_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [BURST_W-1:0] burst_q;
    logic [BURST_W-1:0] cnt_q;
    logic               last;

    assign last = (cnt_q == burst_q - 1'b1);

    // Transfer state, captured parameters and word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            burst_q <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (go_wr || go_rd) begin
                        state_q <= go_wr ? ST_WRITE : ST_RD_REQ;
                        addr_q  <= cfg_addr;
                        burst_q <= cfg_burst;
                        cnt_q   <= '0;
                    end
                end
                ST_WRITE: begin
                    if (mem_ready) begin
                        if (last) state_q <= ST_IDLE;
                        else      cnt_q   <= cnt_q + 1'b1;
                    end
                end
                ST_RD_REQ: begin
                    if (mem_ready) state_q <= ST_RD_DATA;
                end
                ST_RD_DATA: begin
                    if (mem_rvalid) begin
                        if (last) state_q <= ST_IDLE;
                        else      cnt_q   <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Master request signals and buffer strobes derived from the state.
    always_comb begin
        busy     = (state_q != ST_IDLE);
        m_write  = (state_q == ST_WRITE);
        m_read   = (state_q == ST_RD_REQ);
        m_addr   = addr_q;
        m_burst  = burst_q;
        word_idx = cnt_q[WORD_W-1:0];
        bus_we   = (state_q == ST_RD_DATA) && mem_rvalid;
    end
endmodule

// File: rtl/bsm_mux.sv
// Module: bsm_mux
// Hands the memory request signals either to the manual master (sel high)
// or to the test engine (sel low). Pure combinational selection.
module bsm_mux #(
    parameter int ADDR_W  = 24,
    parameter int BURST_W = 3,
    parameter int DATA_W  = 128
) (
    input  logic               sel,
    input  logic               man_read,
    input  logic               man_write,
    input  logic [ADDR_W-1:0]  man_addr,
    input  logic [DATA_W-1:0]  man_wdata,
    input  logic [BURST_W-1:0] man_burst,
    input  logic               eng_read,
    input  logic               eng_write,
    input  logic [ADDR_W-1:0]  eng_addr,
    input  logic [DATA_W-1:0]  eng_wdata,
    input  logic [BURST_W-1:0] eng_burst,
    output logic               out_read,
    output logic               out_write,
    output logic [ADDR_W-1:0]  out_addr,
    output logic [DATA_W-1:0]  out_wdata,
    output logic [BURST_W-1:0] out_burst
);
    // Pick the active master for the memory bus.
    always_comb begin
        if (sel) begin
            out_read  = man_read;
            out_write = man_write;
            out_addr  = man_addr;
            out_wdata = man_wdata;
            out_burst = man_burst;
        end else begin
            out_read  = eng_read;
            out_write = eng_write;
            out_addr  = eng_addr;
            out_wdata = eng_wdata;
            out_burst = eng_burst;
        end
    end
endmodule

// File: rtl/burst_stage_master.sv
// Module: burst_stage_master
// Top of the manual burst access buffer. It connects the register file,
// staging buffer, transfer sequencer and bus multiplexer. It assumes the
// memory returns read data only after it has accepted the read request.
module burst_stage_master import bsm_pkg::*; #(
    parameter int DATA_W  = 128,
    parameter int ADDR_W  = 24,
    parameter int BURST_W = 3,
    parameter int DEPTH   = 4,
    parameter int REG_AW  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               reg_rvalid,
    input  logic               eng_read,
    input  logic               eng_write,
    input  logic [ADDR_W-1:0]  eng_address,
    input  logic [DATA_W-1:0]  eng_wdata,
    input  logic [BURST_W-1:0] eng_burst,
    input  logic               mem_ready,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_rvalid,
    output logic               mem_read,
    output logic               mem_write,
    output logic [ADDR_W-1:0]  mem_address,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [BURST_W-1:0] mem_burst
);
    localparam int SLICES = DATA_W / SLICE_W;
    localparam int WORD_W = $clog2(DEPTH);
    localparam int SL_W   = $clog2(SLICES);

    logic               busy;
    logic               cfg_en;
    logic [ADDR_W-1:0]  cfg_addr;
    logic [BURST_W-1:0] cfg_burst;
    logic               go_wr;
    logic               go_rd;
    logic               sw_we;
    logic [WORD_W-1:0]  sw_word;
    logic [SL_W-1:0]    sw_slice;
    logic [SLICE_W-1:0] sw_rd_data;
    logic               bus_we;
    logic [WORD_W-1:0]  word_idx;
    logic [DATA_W-1:0]  bus_rd_data;
    logic               man_read;
    logic               man_write;
    logic [ADDR_W-1:0]  man_addr;
    logic [BURST_W-1:0] man_burst;

    bsm_regs #(
        .ADDR_W(ADDR_W), .BURST_W(BURST_W), .REG_AW(REG_AW),
        .DEPTH(DEPTH), .SLICES(SLICES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .busy(busy), .buf_slice_rd(sw_rd_data),
        .buf_we(sw_we), .buf_word(sw_word), .buf_slice(sw_slice),
        .cfg_en(cfg_en), .cfg_addr(cfg_addr), .cfg_burst(cfg_burst),
        .go_wr(go_wr), .go_rd(go_rd)
    );

    bsm_buffer #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .SLICES(SLICES)
    ) u_buffer (
        .clk(clk), .rst_n(rst_n),
        .sw_we(sw_we), .sw_word(sw_word), .sw_slice(sw_slice),
        .sw_data(reg_wdata), .sw_rd_data(sw_rd_data),
        .bus_we(bus_we), .bus_word(word_idx), .bus_data(mem_rdata),
        .bus_rd_data(bus_rd_data)
    );

    bsm_engine #(
        .ADDR_W(ADDR_W), .BURST_W(BURST_W), .DEPTH(DEPTH)
    ) u_engine (
        .clk(clk), .rst_n(rst_n),
        .go_wr(go_wr), .go_rd(go_rd),
        .cfg_addr(cfg_addr), .cfg_burst(cfg_burst),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
        .busy(busy), .m_read(man_read), .m_write(man_write),
        .m_addr(man_addr), .m_burst(man_burst),
        .word_idx(word_idx), .bus_we(bus_we)
    );

    bsm_mux #(
        .ADDR_W(ADDR_W), .BURST_W(BURST_W), .DATA_W(DATA_W)
    ) u_mux (
        .sel(cfg_en),
        .man_read(man_read), .man_write(man_write), .man_addr(man_addr),
        .man_wdata(bus_rd_data), .man_burst(man_burst),
        .eng_read(eng_read), .eng_write(eng_write), .eng_addr(eng_address),
        .eng_wdata(eng_wdata), .eng_burst(eng_burst),
        .out_read(mem_read), .out_write(mem_write), .out_addr(mem_address),
        .out_wdata(mem_wdata), .out_burst(mem_burst)
    );
endmodule

// File: rtl/bsm_checker.sv
// Module: bsm_checker
// Protocol and state checks on the manual burst access buffer. It is
// attached to every burst_stage_master instance through the bind below.
module bsm_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              man_en,
    input logic              busy,
    input logic              mem_read,
    input logic              mem_write,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_address
);
    // The enable cannot change while a transfer runs.
    assert_en_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(man_en));

    // An idle manual master issues no requests.
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (man_en && !busy) |-> (!mem_read && !mem_write));

    // The manual master never reads and writes at once.
    assert_rw_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        man_en |-> !(mem_read && mem_write));

    // The burst address holds for the whole transfer.
    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (man_en && busy) |=> (!busy || $stable(mem_address)));

    // A read request is withdrawn once memory has accepted it.
    assert_req_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (man_en && mem_read && mem_ready) |=> !mem_read);

    // A manual write only happens during a transfer.
    assert_write_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (man_en && mem_write) |-> busy);
endmodule

bind burst_stage_master bsm_checker #(.ADDR_W(ADDR_W)) u_bsm_checker (
    .clk(clk), .rst_n(rst_n), .man_en(cfg_en), .busy(busy),
    .mem_read(mem_read), .mem_write(mem_write), .mem_ready(mem_ready),
    .mem_address(mem_address)
);

// File: tb/test_burst_stage_master.sv
// Bench for burst_stage_master: random bursts with a fixed seed, plus
// directed cases for ignored commands, busy-time writes and the buffer race.
module test_burst_stage_master;
    localparam int DATA_W  = 128;
    localparam int ADDR_W  = 24;
    localparam int BURST_W = 3;
    localparam int DEPTH   = 4;
    localparam int REG_AW  = 8;
    localparam int SLICES  = 4;
    localparam int WIN     = 64;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               reg_wr = 1'b0, reg_rd = 1'b0;
    logic [REG_AW-1:0]  reg_addr = '0;
    logic [31:0]        reg_wdata = '0;
    logic [31:0]        reg_rdata;
    logic               reg_rvalid;
    logic               eng_read = 1'b0, eng_write = 1'b0;
    logic [ADDR_W-1:0]  eng_address = '0;
    logic [DATA_W-1:0]  eng_wdata = '0;
    logic [BURST_W-1:0] eng_burst = '0;
    logic               mem_ready = 1'b0, mem_rvalid = 1'b0;
    logic [DATA_W-1:0]  mem_rdata = '0;
    logic               mem_read, mem_write;
    logic [ADDR_W-1:0]  mem_address;
    logic [DATA_W-1:0]  mem_wdata;
    logic [BURST_W-1:0] mem_burst;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] exp_buf [DEPTH][SLICES];

    burst_stage_master #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BURST_W(BURST_W),
        .DEPTH(DEPTH), .REG_AW(REG_AW)
    ) i_burst_stage_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .eng_read(eng_read), .eng_write(eng_write),
        .eng_address(eng_address), .eng_wdata(eng_wdata), .eng_burst(eng_burst),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .mem_read(mem_read), .mem_write(mem_write), .mem_address(mem_address),
        .mem_wdata(mem_wdata), .mem_burst(mem_burst)
    );

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [127:0] buf_word(input int w);
        return {exp_buf[w][3], exp_buf[w][2], exp_buf[w][1], exp_buf[w][0]};
    endfunction

    task automatic reg_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = REG_AW'(idx); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int idx, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = REG_AW'(idx);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic check_buffer(input string req);
        logic [31:0] d;
        for (int w = 0; w < DEPTH; w++)
            for (int s = 0; s < SLICES; s++) begin
                reg_read(WIN + w*SLICES + s, d);
                check(d == exp_buf[w][s], req, d, exp_buf[w][s]);
            end
    endtask

    task automatic fill_buffer();
        for (int w = 0; w < DEPTH; w++)
            for (int s = 0; s < SLICES; s++) begin
                exp_buf[w][s] = $urandom;
                reg_write(WIN + w*SLICES + s, exp_buf[w][s]);
            end
    endtask

    task automatic expect_ctrl(input logic [31:0] expv, input string req);
        logic [31:0] d;
        reg_read(0, d);
        check(d == expv, req, d, expv);
    endtask

    // Manual write burst with random ready stalls (R4, R6).
    task automatic do_write(input logic [ADDR_W-1:0] a, input int b);
        int k = 0;
        int guard = 0;
        bit r;
        reg_write(1, 32'(a));
        reg_write(2, 32'(b));
        reg_write(0, 32'h3);
        while (k < b && guard < 100) begin
            r = (guard > 20) ? 1'b1 : 1'($urandom % 2);
            mem_ready = r;
            #1;
            check(mem_write && mem_address == a && mem_burst == BURST_W'(b), "R4 request",
                  {mem_write, mem_address, mem_burst}, {1'b1, a, BURST_W'(b)});
            if (r) begin
                check(mem_wdata == buf_word(k), "R4 data", mem_wdata, buf_word(k));
                k++;
            end
            @(negedge clk);
            guard++;
        end
        mem_ready = 1'b0;
        #1;
        check(!mem_write, "R6 write ends", mem_write, 0);
        expect_ctrl(32'h1, "R6 busy clear");
    endtask

    // Manual read burst; optionally races a buffer write with word 0 (R5, R8).
    task automatic do_read(input logic [ADDR_W-1:0] a, input int b, input bit collide);
        int k = 0;
        int guard = 0;
        bit r;
        bit acc = 1'b0;
        logic [127:0] d;
        reg_write(1, 32'(a));
        reg_write(2, 32'(b));
        reg_write(0, 32'h5);
        while (!acc && guard < 100) begin
            r = (guard > 10) ? 1'b1 : 1'($urandom % 2);
            mem_ready = r;
            #1;
            check(mem_read && mem_address == a && mem_burst == BURST_W'(b), "R5 request",
                  {mem_read, mem_address, mem_burst}, {1'b1, a, BURST_W'(b)});
            acc = r;
            @(negedge clk);
            guard++;
        end
        mem_ready = 1'b0;
        #1;
        check(!mem_read, "R5 request once", mem_read, 0);
        guard = 0;
        while (k < b && guard < 100) begin
            r = (guard > 10) ? 1'b1 : 1'($urandom % 2);
            mem_rvalid = r;
            d = {$urandom, $urandom, $urandom, $urandom};
            mem_rdata = d;
            if (r) begin
                if (collide && k == 0) begin
                    reg_wr = 1'b1; reg_addr = REG_AW'(WIN + 1); reg_wdata = 32'hDEAD_BEEF;
                end
                for (int s = 0; s < SLICES; s++) exp_buf[k][s] = d[s*32 +: 32];
                k++;
            end
            @(negedge clk);
            reg_wr = 1'b0;
            guard++;
        end
        mem_rvalid = 1'b0;
        expect_ctrl(32'h1, "R6 busy clear after read");
        check_buffer(collide ? "R8 race" : "R5 fill");
    endtask

    initial begin
        logic [31:0] d;
        logic [ADDR_W-1:0] a0;
        void'($urandom(32'h5EED_0042));
        for (int w = 0; w < DEPTH; w++)
            for (int s = 0; s < SLICES; s++) exp_buf[w][s] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        expect_ctrl(32'h0, "R1 ctrl");
        reg_read(1, d); check(d == 0, "R1 addr", d, 0);
        reg_read(2, d); check(d == 0, "R1 burst", d, 0);
        check_buffer("R1 buffer");
        @(negedge clk);
        eng_read = 1'b1; eng_address = 24'h123456; eng_burst = 3'd5;
        #1;
        check(mem_read && mem_address == 24'h123456 && mem_burst == 3'd5, "R1 pass",
              {mem_read, mem_address, mem_burst}, {1'b1, 24'h123456, 3'd5});

        // R2 / R10: register access
        fill_buffer();
        check_buffer("R2 readback");
        @(negedge clk); reg_rd = 1'b1; reg_addr = REG_AW'(WIN);
        @(negedge clk); reg_rd = 1'b0;
        check(reg_rvalid == 1'b1, "R2 rvalid", reg_rvalid, 1);
        reg_write(1, 32'h00AB_CDEF);
        reg_read(1, d); check(d == 32'h00AB_CDEF, "R10 addr", d, 32'h00AB_CDEF);
        reg_write(2, 32'h3);
        reg_read(2, d); check(d == 3, "R10 burst", d, 3);

        // R3: passthrough with enable clear, quiet manual master with enable set
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            eng_read = 1'($urandom); eng_write = 1'($urandom);
            eng_address = ADDR_W'($urandom);
            eng_wdata = {$urandom, $urandom, $urandom, $urandom};
            eng_burst = BURST_W'($urandom);
            #1;
            check(mem_read == eng_read && mem_write == eng_write && mem_address == eng_address
                  && mem_wdata == eng_wdata && mem_burst == eng_burst, "R3 passthrough",
                  {mem_read, mem_write, mem_address}, {eng_read, eng_write, eng_address});
        end
        // R9: read-valid with enable clear
        @(negedge clk); mem_rvalid = 1'b1; mem_rdata = {4{32'hA5A5_5A5A}};
        @(negedge clk); mem_rvalid = 1'b0;
        check_buffer("R9 engine mode");
        reg_write(0, 32'h1);
        @(negedge clk); eng_read = 1'b1; eng_write = 1'b1;
        #1;
        check(!mem_read && !mem_write, "R3 quiet", {mem_read, mem_write}, 0);
        eng_read = 1'b0; eng_write = 1'b0;
        // R9: read-valid with enable set but idle
        @(negedge clk); mem_rvalid = 1'b1; mem_rdata = {4{32'h0F0F_F0F0}};
        @(negedge clk); mem_rvalid = 1'b0;
        check_buffer("R9 idle");

        // R7: ignored commands
        reg_write(2, 32'h0); reg_write(0, 32'h3); #1;
        check(!mem_write && !mem_read, "R7 burst zero", {mem_read, mem_write}, 0);
        reg_write(2, 32'h5); reg_write(0, 32'h5); #1;
        check(!mem_write && !mem_read, "R7 burst too long", {mem_read, mem_write}, 0);
        reg_write(2, 32'h2); reg_write(0, 32'h7); #1;
        check(!mem_write && !mem_read, "R7 both bits", {mem_read, mem_write}, 0);
        reg_write(0, 32'h0); reg_write(0, 32'h2); #1;
        check(!mem_write && !mem_read, "R7 enable clear", {mem_read, mem_write}, 0);
        expect_ctrl(32'h0, "R7 still idle");
        reg_write(0, 32'h1);

        // R4 / R5 directed limits, then random rounds
        do_write(24'h000100, 1);
        do_write(24'hFFFFF0, DEPTH);
        do_read(24'h000200, DEPTH, 1'b1);
        do_read(24'h000300, 1, 1'b0);
        for (int i = 0; i < 8; i++) begin
            fill_buffer();
            do_write(ADDR_W'($urandom), 1 + int'($urandom % DEPTH));
            do_read(ADDR_W'($urandom), 1 + int'($urandom % DEPTH), 1'b0);
        end

        // R8: writes during a stalled write burst are ignored
        fill_buffer();
        a0 = 24'h0C0FFE;
        mem_ready = 1'b0;
        reg_write(1, 32'(a0)); reg_write(2, 32'h2); reg_write(0, 32'h3);
        reg_write(1, 32'h0000_1111);
        reg_write(2, 32'h1);
        reg_write(0, 32'h0);
        reg_write(WIN, 32'h1234_5678);
        reg_write(0, 32'h5);
        #1;
        check(mem_write && mem_address == a0 && mem_burst == 3'd2, "R8 transfer kept",
              {mem_write, mem_address, mem_burst}, {1'b1, a0, 3'd2});
        @(negedge clk); mem_ready = 1'b1; #1;
        check(mem_wdata == buf_word(0), "R8 word0", mem_wdata, buf_word(0));
        @(negedge clk); #1;
        check(mem_wdata == buf_word(1), "R8 word1", mem_wdata, buf_word(1));
        @(negedge clk); mem_ready = 1'b0; #1;
        check(!mem_write, "R8 done", mem_write, 0);
        reg_read(1, d); check(d == 32'(a0), "R8 addr frozen", d, 32'(a0));
        reg_read(2, d); check(d == 2, "R8 burst frozen", d, 2);
        expect_ctrl(32'h1, "R8 enable frozen");
        check_buffer("R8 buffer frozen");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog all actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule